// File: doc/BRIEF.md
# Dual-Clock Cascadable Shift and Hold Register

This block takes a serial bit stream into a chain of shift stages and, on a separate command, copies the whole chain into a hold register whose bits are the parallel outputs. Shifting and copying run on two independent rising-edge clocks. Each of the two register groups has its own asynchronous active-low clear. The hold register lets a new word be shifted in while the outputs stay steady, and all outputs change together on the copy edge.

The chain is built from `N_SECT` sections of `SEC_W` stages each. Each section's last stage feeds the next section's first stage, so together they form one chain of `SEC_W*N_SECT` stages. The final stage is brought out as a serial output, so several instances can be daisy-chained at board or chip level.

The block has no state machine. Both register groups are plain flop banks, each with an async clear. The only sequencing is the ordering of the shift edge against the copy edge. When the two clocks share an edge, the outputs show the chain as it was one shift earlier.

Top module: `dual_clock_shift_store`

## Requirements
- R1: On a rising `sh_clk` with `sh_clr_n` high, stage 0 takes `ser_in` and every stage i>0 takes the previous value of stage i-1. This includes the step from the last stage of one section to the first stage of the next.
- R2: On a rising `st_clk` with `st_clr_n` high, the hold register copies every stage at once. `par_out[i]` then shows stage i, where stage 0 is the stage fed by `ser_in`.
- R3: While `sh_clr_n` is low, every stage is 0 at once, with no clock edge needed. Rising `sh_clk` edges during the clear leave the stages at 0.
- R4: While `st_clr_n` is low, `par_out` is all zeros at once. Rising `st_clk` edges during the clear leave it at zero. This clear leaves the shift stages unchanged, which a later copy shows on `par_out`.
- R5: `ser_out` is stage `SEC_W*N_SECT-1` of the chain, not the held copy. It changes on `sh_clk` and never on `st_clk`.
- R6: When `sh_clk` and `st_clk` rise together, the hold register takes the chain contents from before that edge, so `par_out` stays one shift behind.
- R7: Falling edges of either clock change nothing.
- R8: After either clear goes high again, the next rising edge of that group's clock acts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_clk | input | 1 | Shift clock, rising edge |
| sh_clr_n | input | 1 | Async active-low clear of the shift stages |
| st_clk | input | 1 | Hold-register copy clock, rising edge |
| st_clr_n | input | 1 | Async active-low clear of the hold register |
| ser_in | input | 1 | Serial data into stage 0 |
| par_out | output | SEC_W*N_SECT | Hold register contents; bit i mirrors stage i |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The properties assume the following about the inputs:
- `ser_in` is steady around each rising `sh_clk`.
- A clear changes only while its own clock is low.

The shift and copy properties apply only once enough clock edges have passed since the last clear. A counter in the checker tracks this, so a clear pulse that falls between two edges does not trip them.

The stimulus keeps within these limits. It moves `ser_in` and the clears a quarter period before a rising edge, and only while both clocks are low. The tied-clock case raises both clocks in the same time step, so sampled values set which data is copied.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    // Level at which either clear input empties its register group
    localparam logic CLR_ON = 1'b0;

    function automatic int unsigned chain_len(input int unsigned sec_w, input int unsigned n_sect);
        return sec_w * n_sect;
    endfunction
endpackage

// File: rtl/shreg_section.sv
module shreg_section
    import shreg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         sh_clk,
    input  logic         sh_clr_n,
    input  logic         sin,
    output logic [W-1:0] stages,
    output logic         sout
);
    // One section of the chain: stage 0 loads sin, the rest move up one place
    always_ff @(posedge sh_clk or negedge sh_clr_n) begin
        if (sh_clr_n == CLR_ON) begin
            stages <= '0;
        end else begin
            stages <= {stages[W-2:0], sin};
        end
    end

    assign sout = stages[W-1];
endmodule

// File: rtl/shreg_hold.sv
module shreg_hold
    import shreg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         st_clk,
    input  logic         st_clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge st_clk or negedge st_clr_n) begin
        if (st_clr_n == CLR_ON) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dual_clock_shift_store.sv
module dual_clock_shift_store
    import shreg_pkg::*;
#(
    parameter int unsigned SEC_W  = 8,
    parameter int unsigned N_SECT = 2
) (
    input  logic                        sh_clk,
    input  logic                        sh_clr_n,
    input  logic                        st_clk,
    input  logic                        st_clr_n,
    input  logic                        ser_in,
    output logic [SEC_W*N_SECT-1:0]     par_out,
    output logic                        ser_out
);
    localparam int unsigned TOTAL = chain_len(SEC_W, N_SECT);

    logic [TOTAL-1:0] shift_q;
    logic [N_SECT:0]  link;

    assign link[0] = ser_in;

    for (genvar g = 0; g < N_SECT; g++) begin : g_sect
        shreg_section #(.W(SEC_W)) u_sec (
            .sh_clk   (sh_clk),
            .sh_clr_n (sh_clr_n),
            .sin      (link[g]),
            .stages   (shift_q[g*SEC_W +: SEC_W]),
            .sout     (link[g+1])
        );

        shreg_hold #(.W(SEC_W)) u_hold (
            .st_clk   (st_clk),
            .st_clr_n (st_clr_n),
            .d        (shift_q[g*SEC_W +: SEC_W]),
            .q        (par_out[g*SEC_W +: SEC_W])
        );
    end

    assign ser_out = link[N_SECT];
endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
    parameter int unsigned TOTAL = 16
) (
    input logic             sh_clk,
    input logic             sh_clr_n,
    input logic             st_clk,
    input logic             st_clr_n,
    input logic             ser_in,
    input logic [TOTAL-1:0] shift_q,
    input logic [TOTAL-1:0] par_out,
    input logic             ser_out
);
    // Edges seen since the last clear, saturating; they gate the $past checks
    logic [1:0] sh_seen;
    logic       st_seen;

    always_ff @(posedge sh_clk or negedge sh_clr_n) begin
        if (!sh_clr_n)            sh_seen <= 2'd0;
        else if (sh_seen != 2'd2) sh_seen <= sh_seen + 2'd1;
    end

    always_ff @(posedge st_clk or negedge st_clr_n) begin
        if (!st_clr_n) st_seen <= 1'b0;
        else           st_seen <= 1'b1;
    end

    // R1
    assert_shift_step_R1: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        (sh_seen == 2'd2) |-> (shift_q[TOTAL-1:1] == $past(shift_q[TOTAL-2:0])
                               && shift_q[0] == $past(ser_in)));

    // R2 and R6: the copy holds the chain as sampled at the copy edge
    assert_copy_prev_R2: assert property (@(posedge st_clk) disable iff (!st_clr_n)
        st_seen |-> (par_out == $past(shift_q)));

    // R3
    assert_shclr_empties_R3: assert property (@(negedge sh_clk) disable iff (sh_clr_n)
        (shift_q == '0));

    // R4
    assert_stclr_empties_R4: assert property (@(negedge st_clk) disable iff (st_clr_n)
        (par_out == '0));

    // R5
    assert_tail_bit_R5: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        (sh_seen == 2'd2) |-> (ser_out == $past(shift_q[TOTAL-2])));
endmodule

bind dual_clock_shift_store shreg_checker #(.TOTAL(SEC_W*N_SECT)) u_chk (
    .sh_clk   (sh_clk),
    .sh_clr_n (sh_clr_n),
    .st_clk   (st_clk),
    .st_clr_n (st_clr_n),
    .ser_in   (ser_in),
    .shift_q  (shift_q),
    .par_out  (par_out),
    .ser_out  (ser_out)
);

// File: tb/dual_clock_shift_store_tb.sv
`timescale 1ns/1ps
module dual_clock_shift_store_tb;
    localparam int CLK_P  = 10;
    localparam int SEC_W  = 8;
    localparam int N_SECT = 2;
    localparam int T      = SEC_W * N_SECT;

    logic         sh_clk = 1'b0, st_clk = 1'b0;
    logic         sh_clr_n = 1'b0, st_clr_n = 1'b0;
    logic         ser_in = 1'b0;
    logic [T-1:0] par_out;
    logic         ser_out;

    logic [T-1:0] m_sh = '0;   // reference chain
    logic [T-1:0] m_st = '0;   // reference hold register
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    dual_clock_shift_store #(.SEC_W(SEC_W), .N_SECT(N_SECT)) u_dut (
        .sh_clk(sh_clk), .sh_clr_n(sh_clr_n), .st_clk(st_clk), .st_clr_n(st_clr_n),
        .ser_in(ser_in), .par_out(par_out), .ser_out(ser_out)
    );

    task automatic cmp(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, par_out, m_st);
        cmp(req, {{(T-1){1'b0}}, ser_out}, {{(T-1){1'b0}}, m_sh[T-1]});
    endtask

    // Rising edges of the selected clocks in one time step; checks after rise and after fall
    task automatic pulse(input bit do_sh, input bit do_st, input logic b, input string req);
        ser_in = b;
        #(CLK_P/4);
        if (do_st && st_clr_n) m_st = m_sh;
        if (do_sh && sh_clr_n) m_sh = {m_sh[T-2:0], b};
        if (do_sh) sh_clk = 1'b1;
        if (do_st) st_clk = 1'b1;
        #(CLK_P/4);
        check_all(req);
        #(CLK_P/4);
        sh_clk = 1'b0;
        st_clk = 1'b0;
        #(CLK_P/4);
        check_all("R7 falling edge");
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P);
        check_all("R3 R4 reset state");
        sh_clr_n = 1'b1;
        st_clr_n = 1'b1;
        #(CLK_P/2);

        // R1 R2 R5: sweep every byte value through the chain with its complement
        for (int v = 0; v < 256; v++) begin
            logic [T-1:0] pat;
            pat = {v[7:0], ~v[7:0]};
            for (int i = T-1; i >= 0; i--) pulse(1'b1, 1'b0, pat[i], "R1 R5 shift");
            cmp("R1 chain arithmetic", m_sh, pat);
            pulse(1'b0, 1'b1, 1'b0, "R2 copy");
            cmp("R2 par_out pattern", par_out, pat);
        end

        // R5: copy edges leave ser_out alone
        pulse(1'b1, 1'b0, 1'b1, "R1 shift");
        for (int k = 0; k < 3; k++) pulse(1'b0, 1'b1, 1'b0, "R5 st_clk only");

        // R6: tied clocks, output one shift behind
        for (int k = 0; k < 20; k++) pulse(1'b1, 1'b1, k[0] ^ k[2], "R6 tied clocks");

        // R3: async shift clear, overrides clock
        ser_in = 1'b1;
        sh_clr_n = 1'b0;
        m_sh = '0;
        #(CLK_P/4);
        check_all("R3 async shift clear");
        pulse(1'b1, 1'b0, 1'b1, "R3 clock during clear");
        sh_clr_n = 1'b1;
        #(CLK_P/4);
        for (int k = 0; k < T; k++) pulse(1'b1, 1'b0, 1'b1, "R8 after shift clear");
        pulse(1'b0, 1'b1, 1'b0, "R3 R8 copy after release");

        // R4: async hold clear, overrides clock, shift stages kept
        for (int k = 0; k < 5; k++) pulse(1'b1, 1'b0, 1'b0, "R1 shift");
        st_clr_n = 1'b0;
        m_st = '0;
        #(CLK_P/4);
        check_all("R4 async hold clear");
        pulse(1'b0, 1'b1, 1'b0, "R4 clock during clear");
        st_clr_n = 1'b1;
        #(CLK_P/4);
        pulse(1'b0, 1'b1, 1'b0, "R4 R8 stages kept across hold clear");
        cmp("R4 expected pattern", par_out, {{(T-5){1'b1}}, 5'b0});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule